// File: doc/BRIEF.md
# MSI Snooping Line-State Controller

This block keeps the coherence state (Modified, Shared or Invalid) of a small set of cache lines belonging to one cache in a snooping multiprocessor. The local processor presents read, write and evict requests against a line index. Requests that the current state already allows finish in the cycle they are presented. All other requests raise a bus request with the command the protocol needs, wait for the grant and for the end of the transfer, and then acknowledge the processor. The controller never touches data. It only decides which bus command is needed and which state comes next.

Traffic that other caches place on the bus arrives on the snoop inputs. It is applied in the cycle it appears, including while a local request is stalled. When a snooped read or read-exclusive hits a dirty line, the block raises a flag. That flag tells the data path to write the line back and supply it on the bus ahead of memory. A snoop that lands between the local bus request and its grant can change what the pending request must do. The controller repairs the pending command on the spot.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_ack` and `snp_supply` are low.
- R2: A read (cpu_op 0) or a write (cpu_op 1) to a Modified line raises `cpu_ack` in the same cycle, issues no bus request, and leaves the line Modified.
- R3: A read to an Invalid line requests bus command 0 (read) and ends Shared. A write to an Invalid line requests command 1 (read-exclusive) and ends Modified. `cpu_ack` rises only in the cycle `bus_done` is seen after the grant.
- R4: A read to a Shared line is acknowledged at once with no bus request. A write to a Shared line requests command 2 (data-less invalidate) and ends Modified.
- R5: An evict (cpu_op 2) of a Modified line requests command 3 (write back) and ends Invalid. An evict of a Shared or Invalid line is acknowledged at once, with no bus request, and leaves the line Invalid.
- R6: A snooped read (command 0) that hits a Modified line raises `snp_supply` in the same cycle and moves the line to Shared. A snooped read leaves a Shared or Invalid line unchanged and does not raise `snp_supply`.
- R7: A snooped read-exclusive (command 1) that hits a Modified line raises `snp_supply` and moves the line to Invalid. A snooped read-exclusive or invalidate (command 2) moves a Shared line to Invalid without `snp_supply`. A snooped write back (command 3) changes nothing.
- R8: Once raised, `bus_req` stays high with `bus_cmd` and `bus_idx` unchanged until `bus_gnt`. `cpu_ack` stays low while a bus transaction is outstanding.
- R9: When a snoop and a local request target the same line in the same cycle, the snoop is applied first and the local request is decoded against the resulting state.
- R10: If a pending invalidate loses its Shared line to a snoop before the grant, the request becomes a read-exclusive (command 1) in that same cycle.
- R11: If a pending write back loses its Modified line to a snooped read before the grant, the bus request is withdrawn, `cpu_ack` rises in that cycle and the line ends Invalid.
- R12: A snoop changes only the line named by `snp_idx`. Every other line keeps its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request present, held until `cpu_ack` |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_idx | input | IDX_W | Line targeted by the local request |
| cpu_ack | output | 1 | Local request complete this cycle |
| bus_req | output | 1 | Bus request pending |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 write back |
| bus_idx | output | IDX_W | Line of the pending bus request |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted transaction finished |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_idx | input | IDX_W | Line named by the snooped transaction |
| snp_supply | output | 1 | Write back and supply the snooped line ahead of memory |

## Verification
The bench builds the controller with four lines, which gives a two-bit index. That width is enough to keep one line dirty while others are snooped, so R12 is checked against live neighbours, and it drives the top index value. Line states are inferred only from port behaviour: whether a later request finishes at once or which bus command it raises, and whether a snoop raises the supply flag. Both races between a snoop and a pending request, before the grant, are driven at the exact cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    // State a line takes once its own bus transaction has completed.
    function automatic line_st_e state_after_bus(bus_cmd_e c);
        case (c)
            CMD_RD:   return ST_S;
            CMD_RDX:  return ST_M;
            CMD_UPGR: return ST_M;
            default:  return ST_I;
        endcase
    endfunction

endpackage

// File: rtl/msi_snoop_line.sv
module msi_snoop_line
    import msi_pkg::*;
(
    input  line_st_e st_cur,
    input  logic     hit,
    input  bus_cmd_e cmd,
    output line_st_e st_nxt,
    output logic     supply
);

    always_comb begin
        st_nxt = st_cur;
        supply = 1'b0;
        if (hit) begin
            case (cmd)
                CMD_RD: begin
                    if (st_cur == ST_M) begin
                        st_nxt = ST_S;
                        supply = 1'b1;
                    end
                end
                CMD_RDX: begin
                    supply = (st_cur == ST_M);
                    st_nxt = ST_I;
                end
                CMD_UPGR: st_nxt = ST_I;
                default:  st_nxt = st_cur;
            endcase
        end
    end

endmodule

// File: rtl/msi_cpu_decode.sv
module msi_cpu_decode
    import msi_pkg::*;
(
    input  line_st_e st,
    input  cpu_op_e  op,
    output logic     need_bus,
    output bus_cmd_e cmd,
    output line_st_e st_free
);

    always_comb begin
        need_bus = 1'b0;
        cmd      = CMD_RD;
        st_free  = st;
        case (op)
            OP_READ: begin
                if (st == ST_I) begin
                    need_bus = 1'b1;
                    cmd      = CMD_RD;
                end
            end
            OP_WRITE: begin
                if (st == ST_I) begin
                    need_bus = 1'b1;
                    cmd      = CMD_RDX;
                end else if (st == ST_S) begin
                    need_bus = 1'b1;
                    cmd      = CMD_UPGR;
                end
            end
            OP_EVICT: begin
                if (st == ST_M) begin
                    need_bus = 1'b1;
                    cmd      = CMD_WB;
                end else begin
                    st_free = ST_I;
                end
            end
            default: st_free = st;
        endcase
    end

endmodule

// File: rtl/msi_pending_fix.sv
module msi_pending_fix
    import msi_pkg::*;
(
    input  bus_cmd_e cmd_q,
    input  line_st_e st_now,
    output bus_cmd_e cmd_eff,
    output logic     cancel
);

    // A snoop seen before the grant may invalidate the reason for a request.
    always_comb begin
        cmd_eff = cmd_q;
        cancel  = 1'b0;
        if (cmd_q == CMD_UPGR && st_now == ST_I) begin
            cmd_eff = CMD_RDX;
        end
        if (cmd_q == CMD_WB && st_now != ST_M) begin
            cancel = 1'b1;
        end
    end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_ack,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             bus_done,
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_supply
);

    typedef struct packed {
        phase_e                   phase;
        bus_cmd_e                 cmd;
        logic [IDX_W-1:0]         idx;
        line_st_e [N_LINES-1:0]   lines;
    } ctl_t;

    ctl_t r_q, r_d;

    line_st_e [N_LINES-1:0] lines_q;
    line_st_e [N_LINES-1:0] snp_st;
    logic     [N_LINES-1:0] sup_v;

    assign lines_q = r_q.lines;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        msi_snoop_line u_snp (
            .st_cur (r_q.lines[i]),
            .hit    (snp_valid && (snp_idx == IDX_W'(i))),
            .cmd    (bus_cmd_e'(snp_cmd)),
            .st_nxt (snp_st[i]),
            .supply (sup_v[i])
        );
    end

    assign snp_supply = |sup_v;

    logic     dec_need;
    bus_cmd_e dec_cmd;
    line_st_e dec_free;

    msi_cpu_decode u_dec (
        .st       (snp_st[cpu_idx]),
        .op       (cpu_op_e'(cpu_op)),
        .need_bus (dec_need),
        .cmd      (dec_cmd),
        .st_free  (dec_free)
    );

    bus_cmd_e fix_cmd;
    logic     fix_cancel;

    msi_pending_fix u_fix (
        .cmd_q   (r_q.cmd),
        .st_now  (snp_st[r_q.idx]),
        .cmd_eff (fix_cmd),
        .cancel  (fix_cancel)
    );

    bus_cmd_e cmd_out;

    always_comb begin
        r_d        = r_q;
        r_d.lines  = snp_st;
        cpu_ack    = 1'b0;
        bus_req    = 1'b0;
        cmd_out    = r_q.cmd;
        case (r_q.phase)
            PH_IDLE: begin
                if (cpu_req_valid) begin
                    if (dec_need) begin
                        r_d.phase = PH_REQ;
                        r_d.cmd   = dec_cmd;
                        r_d.idx   = cpu_idx;
                    end else begin
                        cpu_ack              = 1'b1;
                        r_d.lines[cpu_idx]   = dec_free;
                    end
                end
            end
            PH_REQ: begin
                if (fix_cancel) begin
                    cpu_ack            = 1'b1;
                    r_d.lines[r_q.idx] = ST_I;
                    r_d.phase          = PH_IDLE;
                end else begin
                    bus_req  = 1'b1;
                    cmd_out  = fix_cmd;
                    r_d.cmd  = fix_cmd;
                    if (bus_gnt) begin
                        r_d.phase = PH_XFER;
                    end
                end
            end
            PH_XFER: begin
                if (bus_done) begin
                    cpu_ack            = 1'b1;
                    r_d.lines[r_q.idx] = state_after_bus(r_q.cmd);
                    r_d.phase          = PH_IDLE;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase <= PH_IDLE;
            r_q.cmd   <= CMD_RD;
            r_q.idx   <= '0;
            r_q.lines <= {N_LINES{ST_I}};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_cmd = cmd_out;
    assign bus_idx = r_q.idx;

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk
    import msi_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int IDX_W   = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req_valid,
    input logic [1:0]             cpu_op,
    input logic [IDX_W-1:0]       cpu_idx,
    input logic                   cpu_ack,
    input logic                   bus_req,
    input logic [1:0]             bus_cmd,
    input logic [IDX_W-1:0]       bus_idx,
    input logic                   bus_gnt,
    input logic                   snp_valid,
    input logic [1:0]             snp_cmd,
    input logic [IDX_W-1:0]       snp_idx,
    input logic                   snp_supply,
    input line_st_e [N_LINES-1:0] line_st
);

    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_idx)));

    a_r8_no_ack_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ack);

    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req_valid);

    a_r6_supply_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));

    a_r7_supply_leaves_m: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> (line_st[$past(snp_idx)] != ST_M));

    a_r4_write_ends_m: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_op == 2'd1) |=> (line_st[$past(cpu_idx)] == ST_M));

    a_r5_evict_ends_i: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_op == 2'd2) |=> (line_st[$past(cpu_idx)] == ST_I));

    a_r3_read_ends_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_op == 2'd0) |=> (line_st[$past(cpu_idx)] != ST_I));

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(
    .N_LINES (N_LINES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_op        (cpu_op),
    .cpu_idx       (cpu_idx),
    .cpu_ack       (cpu_ack),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_idx       (bus_idx),
    .bus_gnt       (bus_gnt),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_idx       (snp_idx),
    .snp_supply    (snp_supply),
    .line_st       (lines_q)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int IW = 2;

    localparam int SI = 0, SS = 1, SM = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [IW-1:0] cpu_idx = '0;
    logic          cpu_ack;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic          bus_gnt = 1'b0;
    logic          bus_done = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_supply;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int model [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_line_ctrl #(.N_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_ack(cpu_ack),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .bus_gnt(bus_gnt), .bus_done(bus_done),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_supply(snp_supply)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Grant and finish a bus request that is already visible on the ports.
    task automatic finish_xfer(input int exp_cmd, input int idx, input string tag);
        chk(bus_req == 1'b1, {tag, " bus_req"}, int'(bus_req), 1);
        chk(int'(bus_cmd) == exp_cmd, {tag, " bus_cmd"}, int'(bus_cmd), exp_cmd);
        chk(int'(bus_idx) == idx, {tag, " bus_idx"}, int'(bus_idx), idx);
        chk(cpu_ack == 1'b0, {tag, " R8 ack low"}, int'(cpu_ack), 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk(bus_req == 1'b0 && cpu_ack == 1'b0, {tag, " R8 xfer wait"},
            int'({bus_req, cpu_ack}), 0);
        bus_done = 1'b1;
        #1;
        chk(cpu_ack == 1'b1, {tag, " ack on done"}, int'(cpu_ack), 1);
        @(negedge clk);
        bus_done = 1'b0;
        cpu_req_valid = 1'b0;
    endtask

    task automatic do_op(input int op, input int idx, input string tag);
        int st = model[idx];
        bit need;
        int cmd;
        int nxt;
        need = 1'b0; cmd = 0; nxt = st;
        if (op == 0) begin
            if (st == SI) begin need = 1'b1; cmd = 0; nxt = SS; end
        end else if (op == 1) begin
            nxt = SM;
            if (st == SI) begin need = 1'b1; cmd = 1; end
            else if (st == SS) begin need = 1'b1; cmd = 2; end
        end else begin
            nxt = SI;
            if (st == SM) begin need = 1'b1; cmd = 3; end
        end
        cpu_req_valid = 1'b1;
        cpu_op = 2'(op);
        cpu_idx = IW'(idx);
        #1;
        if (!need) begin
            chk(cpu_ack == 1'b1, {tag, " immediate ack"}, int'(cpu_ack), 1);
            chk(bus_req == 1'b0, {tag, " no bus"}, int'(bus_req), 0);
            @(negedge clk);
            cpu_req_valid = 1'b0;
        end else begin
            chk(cpu_ack == 1'b0, {tag, " stall"}, int'(cpu_ack), 0);
            @(negedge clk);
            #1;
            chk(bus_req == 1'b1, {tag, " bus_req up"}, int'(bus_req), 1);
            @(negedge clk);
            #1;
            finish_xfer(cmd, idx, tag);
        end
        model[idx] = nxt;
    endtask

    task automatic do_snoop(input int cmd, input int idx, input string tag);
        bit exp_sup = (model[idx] == SM) && (cmd == 0 || cmd == 1);
        snp_valid = 1'b1;
        snp_cmd = 2'(cmd);
        snp_idx = IW'(idx);
        #1;
        chk(snp_supply == exp_sup, {tag, " snp_supply"}, int'(snp_supply), int'(exp_sup));
        @(negedge clk);
        snp_valid = 1'b0;
        if (cmd == 0 && model[idx] == SM) model[idx] = SS;
        else if (cmd == 1 || cmd == 2) model[idx] = SI;
    endtask

    task automatic t_reset();
        #1;
        chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
        chk(cpu_ack == 1'b0, "R1 cpu_ack", int'(cpu_ack), 0);
        chk(snp_supply == 1'b0, "R1 snp_supply", int'(snp_supply), 0);
        @(negedge clk);
        for (int i = 0; i < NL; i++) do_op(0, i, "R1 line invalid");
    endtask

    task automatic t_invalid_fill();
        for (int i = 0; i < NL; i++) do_snoop(2, i, "R7 invalidate shared");
        do_op(1, 0, "R3 write miss");
        do_op(0, 1, "R3 read miss");
    endtask

    task automatic t_modified_free();
        do_op(0, 0, "R2 read M");
        do_op(1, 0, "R2 write M");
        do_snoop(0, 0, "R6 read hits M");
        do_op(0, 0, "R6 now shared");
    endtask

    task automatic t_shared();
        do_op(0, 1, "R4 read S");
        do_op(1, 1, "R4 write S upgrade");
        do_snoop(1, 1, "R7 rdx hits M");
        do_op(0, 1, "R7 after rdx invalid");
    endtask

    task automatic t_evict();
        do_op(1, 2, "R5 make M");
        do_op(2, 2, "R5 evict M");
        do_op(0, 2, "R5 refill");
        do_op(2, 2, "R5 evict S");
        do_op(2, 2, "R5 evict I");
        do_op(0, 2, "R5 confirm invalid");
    endtask

    task automatic t_snoop_shared();
        do_snoop(0, 1, "R6 read hits S");
        do_op(0, 1, "R6 S kept");
        do_snoop(3, 1, "R7 writeback no effect");
        do_op(0, 1, "R7 S kept after wb");
        do_snoop(1, 1, "R7 rdx hits S");
        do_op(0, 1, "R7 S dropped");
    endtask

    task automatic t_priority();
        do_op(1, 0, "R9 setup M");
        cpu_req_valid = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd0;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 2'd0;
        #1;
        chk(snp_supply == 1'b1, "R9 supply", int'(snp_supply), 1);
        chk(cpu_ack == 1'b0, "R9 write stalls", int'(cpu_ack), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        finish_xfer(1, 0, "R9 rdx after snoop");
        model[0] = SM;
    endtask

    task automatic t_race_upgr();
        if (model[3] != SS) do_op(0, 3, "R10 setup");
        cpu_req_valid = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd3;
        @(negedge clk);
        #1;
        chk(int'(bus_cmd) == 2, "R10 upgrade pending", int'(bus_cmd), 2);
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_idx = 2'd3;
        #1;
        chk(int'(bus_cmd) == 1 && bus_req, "R10 becomes rdx", int'(bus_cmd), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        finish_xfer(1, 3, "R10 rdx");
        model[3] = SM;
        do_snoop(0, 3, "R10 ends M");
    endtask

    task automatic t_race_wb();
        cpu_req_valid = 1'b1; cpu_op = 2'd2; cpu_idx = 2'd0;
        @(negedge clk);
        #1;
        chk(bus_req && int'(bus_cmd) == 3, "R11 wb pending", int'(bus_cmd), 3);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_idx = 2'd0;
        #1;
        chk(snp_supply == 1'b1, "R11 supply", int'(snp_supply), 1);
        chk(bus_req == 1'b0, "R11 withdrawn", int'(bus_req), 0);
        chk(cpu_ack == 1'b1, "R11 ack", int'(cpu_ack), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        cpu_req_valid = 1'b0;
        model[0] = SI;
        do_op(0, 0, "R11 ends invalid");
    endtask

    task automatic t_independent();
        do_op(1, 2, "R12 setup M");
        do_snoop(1, 3, "R12 rdx neighbour");
        do_snoop(2, 1, "R12 inval neighbour");
        do_op(1, 2, "R12 line kept M");
        do_snoop(0, 2, "R12 supply own line");
    endtask

    initial begin
        for (int i = 0; i < NL; i++) model[i] = SI;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_invalid_fill();
        t_modified_free();
        t_shared();
        t_evict();
        t_snoop_shared();
        t_priority();
        t_race_upgr();
        t_race_wb();
        t_independent();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule